// File: doc/BRIEF.md
# Serial Character Retiming Receiver

This block sits behind a 1200-baud FSK demodulator and turns its raw bit stream into whole asynchronous characters. A falling edge on the line opens a frame. The block checks the start bit again half a bit later, then samples eight data bits at their centres, least significant bit first. It checks the stop bit last and places a good character in a holding register. An active-low interrupt then tells the host that a character is waiting.

The host does not read the character in parallel. It pulses its own clock line, and each rising edge moves the next stored bit onto the serial output. If the host holds that line high for a full bit period, retiming is switched off. The output then carries the raw demodulated stream, and the receiver stays idle. The interrupt is driven only in FSK receive mode. In the unpowered mode and in tone-alert mode it stays released.

Top module: `fsk_char_retimer`

## Requirements
- R1: After synchronous reset, irq_n is 1, ser_out is 1, and the receiver waits idle for a start bit.
- R2: A high-to-low transition on raw_bit starts a frame only if the line is still low half a bit period later. A low pulse shorter than that produces no character and no interrupt.
- R3: The bit period is round(CLK_HZ/BAUD) clock cycles. Eight data bits are sampled at bit centres and assembled least significant bit first.
- R4: A character whose stop bit samples low is discarded, and irq_n stays 1. A correct character that follows is still received.
- R5: A character with a high stop bit is stored, and irq_n goes to 0.
- R6: Each rising edge on host_clk puts the next stored bit on ser_out, starting with bit 0. ser_out is stable once host_clk has been low again for 4 cycles.
- R7: The first host_clk rising edge after irq_n falls releases irq_n to 1.
- R8: A character that completes before the previous one is fully read replaces it. Readout restarts at bit 0, and irq_n is 0.
- R9: While host_clk has been high for at least one bit period, ser_out follows raw_bit with a two-cycle lag, irq_n is 1, and characters on raw_bit are not received.
- R10: When zero_pwr is 1 or mode_fsk is 0, irq_n is 1 and no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, nominally 3.579545 MHz |
| rst | input | 1 | Synchronous active-high reset |
| zero_pwr | input | 1 | 1 selects the unpowered mode |
| mode_fsk | input | 1 | 1 selects FSK receive, 0 selects tone-alert |
| host_clk | input | 1 | Host readout clock; held high selects bypass |
| raw_bit | input | 1 | Raw demodulated serial data |
| ser_out | output | 1 | Retimed character bits, or the raw stream in bypass |
| irq_n | output | 1 | Active-low character-ready interrupt |

## Verification
The bench sends several byte patterns (alternating, all ones, all zeros, edge bits only) and compares each readout with a queue of expected characters. A receiver that samples at bit edges, or that assembles bits in the wrong order, would return wrong bytes. It also sends a short low glitch and a frame with a low stop bit. A design that skips the half-bit confirmation, or that ignores the stop bit, would raise the interrupt for these. The overwrite case, both before any read and after a partial read, catches a readout pointer that fails to restart at bit 0. The bypass and mode-gating cases catch an interrupt that stays low, or a receiver that keeps framing, while it should be idle.

// File: rtl/retimer_pkg.sv
package retimer_pkg;

    localparam int CHAR_BITS = 8;

    typedef logic [CHAR_BITS-1:0] char_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // Rounded clock cycles per bit
    function automatic int bit_cycles(input int clk_hz, input int baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/rx_framer.sv
module rx_framer
    import retimer_pkg::*;
#(
    parameter int BIT_CYC = 2983
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  line,
    output logic  char_valid,
    output char_t char_data
);
    localparam int HALF_CYC = BIT_CYC / 2;
    localparam int CW       = $clog2(BIT_CYC + 1);
    localparam int IW       = $clog2(CHAR_BITS + 1);

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic          line_d;
    char_t         shreg;
    logic          tick;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            cnt        <= '0;
            idx        <= '0;
            line_d     <= 1'b1;
            shreg      <= '0;
            char_valid <= 1'b0;
        end else begin
            line_d     <= line;
            char_valid <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (line_d && !line) begin
                            state <= RX_START;
                            cnt   <= CW'(HALF_CYC - 1);
                        end
                    end
                    RX_START: begin
                        if (tick) begin
                            if (!line) begin
                                state <= RX_DATA;
                                cnt   <= CW'(BIT_CYC - 1);
                                idx   <= '0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tick) begin
                            shreg <= {line, shreg[CHAR_BITS-1:1]};
                            cnt   <= CW'(BIT_CYC - 1);
                            idx   <= idx + 1'b1;
                            if (idx == IW'(CHAR_BITS - 1))
                                state <= RX_STOP;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tick) begin
                            state      <= RX_IDLE;
                            char_valid <= line;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign char_data = shreg;

    AST_DATA_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DATA) |-> (idx < IW'(CHAR_BITS))); // R3
    AST_VALID_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> (state == RX_IDLE)); // R4

endmodule

// File: rtl/char_store.sv
module char_store
    import retimer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  load,
    input  char_t din,
    input  logic  shift,
    output logic  ser_q,
    output logic  irq
);
    localparam int PW = $clog2(CHAR_BITS);

    char_t         hold;
    logic [PW-1:0] ptr;
    logic          load_ok;

    assign load_ok = load && !clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            ptr   <= '0;
            ser_q <= 1'b1;
            irq   <= 1'b0;
        end else begin
            if (load_ok) begin
                hold <= din;
                ptr  <= '0;
                irq  <= 1'b1;
            end else if (shift) begin
                ser_q <= hold[ptr];
                ptr   <= ptr + 1'b1;
                irq   <= 1'b0;
            end
            if (clear)
                irq <= 1'b0;
        end
    end

    AST_SHIFT_RELEASES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (shift && !load_ok) |=> !irq); // R7
    AST_IRQ_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(load)); // R5
    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        clear |=> !irq); // R9

endmodule

// File: rtl/fsk_char_retimer.sv
module fsk_char_retimer
    import retimer_pkg::*;
#(
    parameter int CLK_HZ = 3579545,
    parameter int BAUD   = 1200
) (
    input  logic clk,
    input  logic rst,
    input  logic zero_pwr,
    input  logic mode_fsk,
    input  logic host_clk,
    input  logic raw_bit,
    output logic ser_out,
    output logic irq_n
);
    localparam int BIT_CYC  = bit_cycles(CLK_HZ, BAUD);
    localparam int HOLD_CYC = BIT_CYC;
    localparam int HW       = $clog2(HOLD_CYC + 1);

    logic [1:0]    raw_sync;
    logic [1:0]    hck_sync;
    logic          hck_d;
    logic [HW-1:0] hold_cnt;
    logic          raw_s;
    logic          hck_s;
    logic          hck_rise;
    logic          bypass;
    logic          active;
    logic          rx_valid;
    char_t         rx_char;
    logic          ser_q;
    logic          irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_sync <= 2'b11;
            hck_sync <= 2'b00;
            hck_d    <= 1'b0;
            hold_cnt <= '0;
        end else begin
            raw_sync <= {raw_sync[0], raw_bit};
            hck_sync <= {hck_sync[0], host_clk};
            hck_d    <= hck_sync[1];
            if (!hck_sync[1])
                hold_cnt <= '0;
            else if (hold_cnt != HW'(HOLD_CYC))
                hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign raw_s    = raw_sync[1];
    assign hck_s    = hck_sync[1];
    assign hck_rise = hck_s && !hck_d;
    assign bypass   = (hold_cnt == HW'(HOLD_CYC));
    assign active   = !zero_pwr && mode_fsk;

    rx_framer #(.BIT_CYC(BIT_CYC)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .enable     (active && !bypass),
        .line       (raw_s),
        .char_valid (rx_valid),
        .char_data  (rx_char)
    );

    char_store u_store (
        .clk   (clk),
        .rst   (rst),
        .clear (!active || bypass),
        .load  (rx_valid),
        .din   (rx_char),
        .shift (hck_rise),
        .ser_q (ser_q),
        .irq   (irq)
    );

    assign ser_out = bypass ? raw_s : ser_q;
    assign irq_n   = !irq;

    AST_UNPOWERED_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
        !active |=> irq_n); // R10
    AST_BYPASS_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
        bypass |=> irq_n); // R9

endmodule

// File: tb/tb_fsk_char_retimer.sv
module tb_fsk_char_retimer;

    localparam int CLK_PERIOD = 10;
    localparam int T_HZ       = 19200;
    localparam int T_BAUD     = 1200;
    localparam int BITC       = (T_HZ + T_BAUD / 2) / T_BAUD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic zero_pwr = 1'b0;
    logic mode_fsk = 1'b1;
    logic host_clk = 1'b0;
    logic raw_bit = 1'b1;
    logic ser_out;
    logic irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fsk_char_retimer #(.CLK_HZ(T_HZ), .BAUD(T_BAUD)) dut (
        .clk(clk), .rst(rst), .zero_pwr(zero_pwr), .mode_fsk(mode_fsk),
        .host_clk(host_clk), .raw_bit(raw_bit), .ser_out(ser_out), .irq_n(irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: sends a frame, queues it as expected when it should arrive
    task automatic send_char(input logic [7:0] b, input logic stop, input bit expect_it);
        raw_bit = 1'b0; wait_cyc(BITC);
        for (int i = 0; i < 8; i++) begin
            raw_bit = b[i]; wait_cyc(BITC);
        end
        raw_bit = stop; wait_cyc(BITC);
        raw_bit = 1'b1; wait_cyc(BITC);
        if (expect_it) exp_q.push_back(b);
    endtask

    task automatic pulse(output logic v);
        host_clk = 1'b1; wait_cyc(3);
        host_clk = 1'b0; wait_cyc(4);
        v = ser_out;
    endtask

    // Monitor: reads a character and compares it with the queue head
    task automatic read_check(input string req, input bit chk_irq);
        logic [7:0] got;
        logic [7:0] want;
        for (int i = 0; i < 8; i++) begin
            pulse(got[i]);
            if (i == 0 && chk_irq) chk("R7 irq released by first edge", int'(irq_n), 1);
        end
        want = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(req, int'(got), int'(want));
    endtask

    initial begin
        logic dummy;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        chk("R1 reset irq_n", int'(irq_n), 1);
        chk("R1 reset ser_out", int'(ser_out), 1);

        send_char(8'hA5, 1'b1, 1'b1);
        chk("R5 irq asserted", int'(irq_n), 0);
        read_check("R3 R6 byte A5", 1'b1);
        foreach (exp_q[i]) ;
        send_char(8'h3C, 1'b1, 1'b1); read_check("R3 R6 byte 3C", 1'b1);
        send_char(8'hFF, 1'b1, 1'b1); read_check("R3 byte FF", 1'b0);
        send_char(8'h00, 1'b1, 1'b1); read_check("R3 byte 00", 1'b0);
        send_char(8'h81, 1'b1, 1'b1); read_check("R3 byte 81", 1'b0);

        // R4: framing error
        send_char(8'h55, 1'b0, 1'b0);
        wait_cyc(BITC);
        chk("R4 bad stop no irq", int'(irq_n), 1);
        send_char(8'hC3, 1'b1, 1'b1); read_check("R4 recovery C3", 1'b0);

        // R2: glitch rejected
        raw_bit = 1'b0; wait_cyc(4);
        raw_bit = 1'b1; wait_cyc(BITC * 12);
        chk("R2 glitch no irq", int'(irq_n), 1);

        // R8: overwrite before read, and after partial read
        send_char(8'h12, 1'b1, 1'b0);
        send_char(8'h34, 1'b1, 1'b1);
        chk("R8 irq stays low", int'(irq_n), 0);
        read_check("R8 overwrite 34", 1'b0);
        send_char(8'h9E, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) pulse(dummy);
        send_char(8'h6B, 1'b1, 1'b1);
        chk("R8 irq after partial read", int'(irq_n), 0);
        read_check("R8 restart at bit 0", 1'b0);

        // R9: bypass
        send_char(8'h5A, 1'b1, 1'b0);
        host_clk = 1'b1; wait_cyc(BITC + 6);
        chk("R9 bypass irq released", int'(irq_n), 1);
        raw_bit = 1'b0; wait_cyc(3);
        chk("R9 raw low passes", int'(ser_out), 0);
        raw_bit = 1'b1; wait_cyc(3);
        chk("R9 raw high passes", int'(ser_out), 1);
        send_char(8'h77, 1'b1, 1'b0);
        chk("R9 no rx in bypass", int'(irq_n), 1);
        host_clk = 1'b0; wait_cyc(6);
        chk("R9 no char after bypass", int'(irq_n), 1);
        send_char(8'h66, 1'b1, 1'b1); read_check("R9 rx after bypass 66", 1'b0);

        // R10: inactive modes
        mode_fsk = 1'b0;
        send_char(8'h11, 1'b1, 1'b0);
        chk("R10 tone mode no irq", int'(irq_n), 1);
        mode_fsk = 1'b1;
        zero_pwr = 1'b1;
        send_char(8'h22, 1'b1, 1'b0);
        chk("R10 zero power no irq", int'(irq_n), 1);
        zero_pwr = 1'b0; wait_cyc(4);
        chk("R10 no late irq", int'(irq_n), 1);
        send_char(8'h4D, 1'b1, 1'b1); read_check("R10 rx after re-enable 4D", 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule